// File: doc/BRIEF.md
# AC-Coupled Test Pulse Generator

This block produces the transmitter-side stimulus for boundary testing of AC-coupled differential links. A capacitor in the link blocks a steady level, so the receiver only sees edges. To give it edges, the block turns the boundary update-register bit into a short sequence of transitions. The sequence is paced by the falling edges of the test clock and by the state of the test access port (TAP) controller. Each lane drives a differential pair and an output enable.

The block runs on a fast system clock. A one-cycle strobe, `tck_fall`, marks each falling edge of the test clock. The TAP state and the decoded instruction modes arrive as plain inputs. A priority decode picks one of five drive sources:

- disabled (high impedance);
- a continuous train;
- a single pulse;
- a static level;
- the mission data, which passes straight through.

A small sequencer keeps one inversion flag, shared by all lanes, that decides whether the lanes drive the data or its complement. Every output is a register, so the outputs follow the inputs sampled at a clock edge, one edge later.

Top module: `ac_pulse_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every lane drives `tx_p`=0, `tx_n`=1 and `tx_oe`=0 after that edge. The sequencer also forgets any inversion and any earlier idle visit, and the block treats the modes present at the first edge after reset as newly selected.
- R2: `tx_n` is always the bitwise complement of `tx_p`.
- R3: The drive source is chosen by priority: `mode_highz`, then `mode_train`, then `mode_pulse`, then `mode_extest`, then mission. When `mode_highz` is set, `tx_oe` and `tx_p` are 0 after the next edge.
- R4: When no mode input is set, `tx_p` follows `mission_data` and `tx_oe` follows `mission_oe`, one edge later.
- R5: When static mode is the chosen source, `tx_p` equals `upd_data` and `tx_oe` equals `upd_oe`, one edge later. Strobes and TAP states have no effect on the output.
- R6: In pulse or train mode, a strobe while `tap_state` is an update state (Update-DR = 5, Update-IR = 13) drives the non-inverted `upd_data`. `tx_oe` equals `upd_oe` throughout pulse and train modes.
- R7: In pulse or train mode, the first strobe in Run-Test/Idle (`tap_state` = 12) drives `~upd_data`. "First" means the previous strobe was in another state, or there has been none since reset, Test-Logic-Reset or a mode change.
- R8: In pulse mode, further strobes while the TAP state stays in Run-Test/Idle keep the inverted level.
- R9: In pulse or train mode, a strobe in any state other than Run-Test/Idle, after an inversion, returns the output to non-inverted data.
- R10: In train mode, every strobe after the first while the TAP state stays in Run-Test/Idle flips the inversion.
- R11: `tap_state` = 15 (Test-Logic-Reset) clears the inversion and the idle history at the next edge, with or without a strobe. Any change of the four mode inputs clears them at that edge too.
- R12: In pulse or train mode, with no strobe, no Test-Logic-Reset and all inputs steady, `tx_p` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_fall | input | 1 | One-cycle strobe marking a test-clock falling edge |
| tap_state | input | 4 | Current TAP controller state code |
| mode_extest | input | 1 | Static boundary drive selected |
| mode_pulse | input | 1 | Single AC pulse mode selected |
| mode_train | input | 1 | Continuous AC train mode selected |
| mode_highz | input | 1 | Test outputs disabled |
| upd_data | input | NLANE | Boundary update-register data, one bit per lane |
| upd_oe | input | NLANE | Boundary update-register output enable per lane |
| mission_data | input | NLANE | Functional data, passed through when no mode is set |
| mission_oe | input | NLANE | Functional output enable |
| tx_p | output | NLANE | True side of each differential test output |
| tx_n | output | NLANE | Complement side of each differential test output |
| tx_oe | output | NLANE | Output-buffer enable per lane |

## Verification
The hardest case to reach from the ports is the inversion history: an idle visit that a mode change or Test-Logic-Reset has cut short. There, the next idle strobe must count as a first strobe again, not as a repeat.

The stimulus reaches this case in two ways. It changes the mode set while the TAP state stays in Run-Test/Idle with a train running. It also resets the block in the middle of an inverted pulse. In both cases it then applies a strobe that is still in Run-Test/Idle and checks that the output inverts, without toggling back and without holding the old level.

// File: rtl/acpg_pkg.sv
package acpg_pkg;

  // TAP controller state codes as delivered on tap_state
  typedef enum logic [3:0] {
    TS_EXIT2_DR = 4'd0,
    TS_EXIT1_DR = 4'd1,
    TS_SHIFT_DR = 4'd2,
    TS_PAUSE_DR = 4'd3,
    TS_SEL_IR   = 4'd4,
    TS_UPD_DR   = 4'd5,
    TS_CAP_DR   = 4'd6,
    TS_SEL_DR   = 4'd7,
    TS_EXIT2_IR = 4'd8,
    TS_EXIT1_IR = 4'd9,
    TS_SHIFT_IR = 4'd10,
    TS_PAUSE_IR = 4'd11,
    TS_IDLE     = 4'd12,
    TS_UPD_IR   = 4'd13,
    TS_CAP_IR   = 4'd14,
    TS_RESET    = 4'd15
  } tap_state_e;

  localparam int TAP_W = 4;

  // Drive source picked by the priority decode
  typedef enum logic [2:0] {
    SEL_MISSION = 3'd0,
    SEL_STATIC  = 3'd1,
    SEL_PULSE   = 3'd2,
    SEL_TRAIN   = 3'd3,
    SEL_OFF     = 3'd4
  } drv_sel_e;

endpackage

// File: rtl/acpg_mode_dec.sv
module acpg_mode_dec
  import acpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     mode_extest,
  input  logic     mode_pulse,
  input  logic     mode_train,
  input  logic     mode_highz,
  output drv_sel_e sel,
  output logic     mode_chg
);

  localparam int MODE_N = 4;

  logic [MODE_N-1:0] mode_vec;
  logic [MODE_N-1:0] mode_q;

  assign mode_vec = {mode_highz, mode_train, mode_pulse, mode_extest};

  // Priority: off > train > pulse > static > mission
  always_comb begin
    if (mode_highz)       sel = SEL_OFF;
    else if (mode_train)  sel = SEL_TRAIN;
    else if (mode_pulse)  sel = SEL_PULSE;
    else if (mode_extest) sel = SEL_STATIC;
    else                  sel = SEL_MISSION;
  end

  // Remember the mode set so that an instruction change can be seen
  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else     mode_q <= mode_vec;
  end

  assign mode_chg = (mode_vec != mode_q);

endmodule

// File: rtl/acpg_phase_seq.sv
module acpg_phase_seq
  import acpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tck_fall,
  input  logic [TAP_W-1:0] tap_state,
  input  drv_sel_e         sel,
  input  logic             mode_chg,
  output logic             inv_nxt
);

  logic       inv_q;
  logic       idle_q;   // last strobe landed in Run-Test/Idle
  logic       idle_nxt;
  logic       ac_mode;
  tap_state_e ts;

  assign ts      = tap_state_e'(tap_state);
  assign ac_mode = (sel == SEL_PULSE) || (sel == SEL_TRAIN);

  always_comb begin
    inv_nxt  = inv_q;
    idle_nxt = idle_q;
    if (tck_fall) idle_nxt = (ts == TS_IDLE);
    if ((ts == TS_RESET) || mode_chg) idle_nxt = 1'b0;

    if ((ts == TS_RESET) || mode_chg || !ac_mode) begin
      inv_nxt = 1'b0;
    end else if (tck_fall) begin
      if (ts == TS_IDLE) begin
        if (!idle_q)                inv_nxt = 1'b1;
        else if (sel == SEL_TRAIN)  inv_nxt = ~inv_q;
      end else begin
        inv_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q  <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      inv_q  <= inv_nxt;
      idle_q <= idle_nxt;
    end
  end

endmodule

// File: rtl/acpg_lane_drv.sv
module acpg_lane_drv
  import acpg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  drv_sel_e sel,
  input  logic     inv,
  input  logic     upd_d,
  input  logic     upd_en,
  input  logic     mis_d,
  input  logic     mis_en,
  output logic     p_out,
  output logic     n_out,
  output logic     en_out
);

  logic p_nxt;
  logic en_nxt;

  always_comb begin
    unique case (sel)
      SEL_OFF:               begin p_nxt = 1'b0;        en_nxt = 1'b0;   end
      SEL_TRAIN, SEL_PULSE:  begin p_nxt = upd_d ^ inv; en_nxt = upd_en; end
      SEL_STATIC:            begin p_nxt = upd_d;       en_nxt = upd_en; end
      default:               begin p_nxt = mis_d;       en_nxt = mis_en; end
    endcase
  end

  // The two legs are separate registers loaded with opposite values
  always_ff @(posedge clk) begin
    if (rst) begin
      p_out  <= 1'b0;
      n_out  <= 1'b1;
      en_out <= 1'b0;
    end else begin
      p_out  <= p_nxt;
      n_out  <= ~p_nxt;
      en_out <= en_nxt;
    end
  end

endmodule

// File: rtl/ac_pulse_gen.sv
module ac_pulse_gen
  import acpg_pkg::*;
#(
  parameter int NLANE = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tck_fall,
  input  logic [TAP_W-1:0] tap_state,
  input  logic             mode_extest,
  input  logic             mode_pulse,
  input  logic             mode_train,
  input  logic             mode_highz,
  input  logic [NLANE-1:0] upd_data,
  input  logic [NLANE-1:0] upd_oe,
  input  logic [NLANE-1:0] mission_data,
  input  logic [NLANE-1:0] mission_oe,
  output logic [NLANE-1:0] tx_p,
  output logic [NLANE-1:0] tx_n,
  output logic [NLANE-1:0] tx_oe
);

  drv_sel_e sel;
  logic     mode_chg;
  logic     inv_nxt;

  acpg_mode_dec u_dec (
    .clk         (clk),
    .rst         (rst),
    .mode_extest (mode_extest),
    .mode_pulse  (mode_pulse),
    .mode_train  (mode_train),
    .mode_highz  (mode_highz),
    .sel         (sel),
    .mode_chg    (mode_chg)
  );

  acpg_phase_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .tck_fall  (tck_fall),
    .tap_state (tap_state),
    .sel       (sel),
    .mode_chg  (mode_chg),
    .inv_nxt   (inv_nxt)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    acpg_lane_drv u_drv (
      .clk    (clk),
      .rst    (rst),
      .sel    (sel),
      .inv    (inv_nxt),
      .upd_d  (upd_data[g]),
      .upd_en (upd_oe[g]),
      .mis_d  (mission_data[g]),
      .mis_en (mission_oe[g]),
      .p_out  (tx_p[g]),
      .n_out  (tx_n[g]),
      .en_out (tx_oe[g])
    );
  end

endmodule

// File: rtl/acpg_chk.sv
module acpg_chk #(
  parameter int NLANE = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             tck_fall,
  input logic [3:0]       tap_state,
  input logic             mode_extest,
  input logic             mode_pulse,
  input logic             mode_train,
  input logic             mode_highz,
  input logic [NLANE-1:0] upd_data,
  input logic [NLANE-1:0] upd_oe,
  input logic [NLANE-1:0] mission_data,
  input logic [NLANE-1:0] mission_oe,
  input logic [NLANE-1:0] tx_p,
  input logic [NLANE-1:0] tx_n,
  input logic [NLANE-1:0] tx_oe
);

  logic       armed;
  logic [3:0] modes;

  assign modes = {mode_highz, mode_train, mode_pulse, mode_extest};

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (tx_p == '0 && tx_n == '1 && tx_oe == '0));                        // R1

  AST_LEGS_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
    armed |-> (tx_n == ~tx_p));                                                // R2

  AST_HIGHZ_OFF: assert property (@(posedge clk) disable iff (rst)
    mode_highz |=> (tx_oe == '0 && tx_p == '0));                               // R3

  AST_MISSION_PASS: assert property (@(posedge clk) disable iff (rst)
    (modes == 4'b0000) |=> (tx_p == $past(mission_data) && tx_oe == $past(mission_oe))); // R4

  AST_STATIC_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (modes == 4'b0001) |=> (tx_p == $past(upd_data) && tx_oe == $past(upd_oe)));  // R5

  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (armed && !mode_highz && (mode_pulse || mode_train) && !tck_fall &&
     tap_state != 4'd15 && $stable(modes) && $stable(upd_data) && $stable(upd_oe))
    |=> $stable(tx_p));                                                        // R12

endmodule

bind ac_pulse_gen acpg_chk #(.NLANE(NLANE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tck_fall     (tck_fall),
  .tap_state    (tap_state),
  .mode_extest  (mode_extest),
  .mode_pulse   (mode_pulse),
  .mode_train   (mode_train),
  .mode_highz   (mode_highz),
  .upd_data     (upd_data),
  .upd_oe       (upd_oe),
  .mission_data (mission_data),
  .mission_oe   (mission_oe),
  .tx_p         (tx_p),
  .tx_n         (tx_n),
  .tx_oe        (tx_oe)
);

// File: tb/sim_ac_pulse_gen.sv
`timescale 1ns/1ps
module sim_ac_pulse_gen;

  localparam int NLANE = 2;
  localparam int NV    = 29;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             tck_fall = 1'b0;
  logic [3:0]       tap_state = 4'd15;
  logic             mode_extest = 1'b0, mode_pulse = 1'b0, mode_train = 1'b0, mode_highz = 1'b0;
  logic [NLANE-1:0] upd_data = '0, upd_oe = '0, mission_data = '0, mission_oe = '0;
  logic [NLANE-1:0] tx_p, tx_n, tx_oe;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  ac_pulse_gen #(.NLANE(NLANE)) u0 (
    .clk(clk), .rst(rst), .tck_fall(tck_fall), .tap_state(tap_state),
    .mode_extest(mode_extest), .mode_pulse(mode_pulse), .mode_train(mode_train),
    .mode_highz(mode_highz), .upd_data(upd_data), .upd_oe(upd_oe),
    .mission_data(mission_data), .mission_oe(mission_oe),
    .tx_p(tx_p), .tx_n(tx_n), .tx_oe(tx_oe)
  );

  // mode field order: {highz, train, pulse, extest}
  typedef struct packed {
    logic [3:0] req;
    logic       fall;
    logic [3:0] tap;
    logic [3:0] md;
    logic [1:0] ud;
    logic [1:0] uoe;
    logic [1:0] mis;
    logic [1:0] moe;
    logic [1:0] ep;
    logic [1:0] eoe;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    {4'd4,  1'b0, 4'd15, 4'b0000, 2'b10, 2'b11, 2'b01, 2'b10, 2'b01, 2'b10}, // R4 mission
    {4'd3,  1'b0, 4'd15, 4'b1000, 2'b10, 2'b11, 2'b01, 2'b10, 2'b00, 2'b00}, // R3 off
    {4'd5,  1'b1, 4'd12, 4'b0001, 2'b10, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R5 static
    {4'd5,  1'b1, 4'd12, 4'b0001, 2'b10, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R5 strobe ignored
    {4'd6,  1'b1, 4'd5,  4'b0010, 2'b10, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R6 update-DR
    {4'd12, 1'b0, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R12 no strobe
    {4'd7,  1'b1, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R7 first idle
    {4'd8,  1'b1, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R8 hold
    {4'd12, 1'b0, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R12
    {4'd8,  1'b1, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R8 hold
    {4'd9,  1'b1, 4'd7,  4'b0010, 2'b10, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R9 leave idle
    {4'd6,  1'b1, 4'd5,  4'b0010, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R6 new data
    {4'd7,  1'b1, 4'd12, 4'b0010, 2'b01, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R7
    {4'd11, 1'b0, 4'd15, 4'b0010, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R11 TLR clears
    {4'd6,  1'b1, 4'd13, 4'b0100, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R6 update-IR
    {4'd10, 1'b1, 4'd12, 4'b0100, 2'b01, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R10 first
    {4'd10, 1'b1, 4'd12, 4'b0100, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R10 toggle
    {4'd12, 1'b0, 4'd12, 4'b0100, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R12
    {4'd10, 1'b1, 4'd12, 4'b0100, 2'b01, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R10
    {4'd10, 1'b1, 4'd12, 4'b0100, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R10
    {4'd10, 1'b1, 4'd12, 4'b0100, 2'b01, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R10
    {4'd11, 1'b0, 4'd12, 4'b0110, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R11 mode change
    {4'd10, 1'b1, 4'd12, 4'b0110, 2'b01, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R10 restart
    {4'd9,  1'b1, 4'd1,  4'b0110, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R9
    {4'd3,  1'b0, 4'd1,  4'b1110, 2'b01, 2'b11, 2'b01, 2'b10, 2'b00, 2'b00}, // R3 off wins
    {4'd3,  1'b1, 4'd5,  4'b0011, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11}, // R3 pulse over static
    {4'd3,  1'b1, 4'd12, 4'b0011, 2'b01, 2'b11, 2'b01, 2'b10, 2'b10, 2'b11}, // R3
    {4'd5,  1'b0, 4'd12, 4'b0001, 2'b11, 2'b01, 2'b01, 2'b10, 2'b11, 2'b01}, // R5 enable
    {4'd4,  1'b0, 4'd12, 4'b0000, 2'b11, 2'b01, 2'b10, 2'b11, 2'b10, 2'b11}  // R4
  };

  function automatic string rname(logic [3:0] r);
    case (r)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  task automatic check(string req, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req, logic [1:0] ep, logic [1:0] eoe);
    check(req, "tx_p", tx_p, ep);
    check(req, "tx_oe", tx_oe, eoe);
    check("R2", "tx_n", tx_n, ~ep);
  endtask

  task automatic drive(logic f, logic [3:0] tap, logic [3:0] md, logic [1:0] ud,
                       logic [1:0] uoe, logic [1:0] mis, logic [1:0] moe);
    @(negedge clk);
    tck_fall = f; tap_state = tap;
    {mode_highz, mode_train, mode_pulse, mode_extest} = md;
    upd_data = ud; upd_oe = uoe; mission_data = mis; mission_oe = moe;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", "tx_p", tx_p, 2'b00);
    check("R1", "tx_n", tx_n, 2'b11);
    check("R1", "tx_oe", tx_oe, 2'b00);
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].fall, VEC[i].tap, VEC[i].md, VEC[i].ud, VEC[i].uoe, VEC[i].mis, VEC[i].moe);
      check_all(rname(VEC[i].req), VEC[i].ep, VEC[i].eoe);
    end

    // Reset in the middle of an inverted pulse
    drive(1'b1, 4'd5,  4'b0010, 2'b10, 2'b11, 2'b00, 2'b00);
    check_all("R6", 2'b10, 2'b11);
    drive(1'b1, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b00, 2'b00);
    check_all("R7", 2'b01, 2'b11);
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    check("R1", "tx_p", tx_p, 2'b00);
    check("R1", "tx_n", tx_n, 2'b11);
    check("R1", "tx_oe", tx_oe, 2'b00);
    @(negedge clk) rst = 1'b0;
    // first edge after reset sees a mode change: inversion stays cleared (R11)
    drive(1'b0, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b00, 2'b00);
    check_all("R11", 2'b10, 2'b11);
    // idle history was cleared, so this strobe inverts again (R7)
    drive(1'b1, 4'd12, 4'b0010, 2'b10, 2'b11, 2'b00, 2'b00);
    check_all("R7", 2'b01, 2'b11);
    // TLR without strobe clears inversion (R11)
    drive(1'b0, 4'd15, 4'b0010, 2'b10, 2'b11, 2'b00, 2'b00);
    check_all("R11", 2'b10, 2'b11);

    finish_run();
  end

endmodule